// File: doc/BRIEF.md
# Serial Interrupt Bus Device Agent

This block is the device end of a shared, single-wire serial interrupt bus. It watches a small set of local interrupt/data lines and reports their levels to the bus host. Each report takes one slot of a time-multiplexed bus cycle. A cycle opens with a low Start Frame pulse. A run of three-clock data frames follows, and a low Stop Frame closes the cycle. The agent never learns the bus mode from a pin. It times the low part of every Stop Frame and chooses the behaviour for the next cycle from that width.

In quiet mode the agent can open a cycle on its own. It drives a single low clock while the bus is idle whenever one of its lines has a change that has not yet been reported, and the host then stretches that pulse. In continuous mode the agent stays passive and only answers cycles that the host opens. The agent counts clock periods from the end of the Start Frame, whichever device opened it. In each of its own slots it pulls the wire low if its line is low, restores the wire high one clock later, and then lets go. The outputs are a drive enable and a drive value for an open-drain style pad. The bus level comes back in through `bus_in`. There is no data stream with back-pressure, so every pin is a plain per-clock control signal.

Top module: `sirq_agent`

## Requirements
- R1: After reset the agent drives nothing (`drv_en` = 0) and behaves as in continuous mode, so a line change alone does not make it open a cycle.
- R2: In continuous mode the agent never drives a Start Frame, whatever its lines do.
- R3: In quiet mode, with a change still unreported and the bus idle and high, the agent drives the bus low (`drv_en`=1, `drv_val`=0) for exactly one clock. It then releases the bus (`drv_en`=0) and does not drive it high.
- R4: The agent opens a cycle only from the idle state, between a Stop Frame and the next Start Frame. It never drives a Start Frame while a cycle is running.
- R5: Let period 0 be the clock edge that first samples `bus_in` high after a Start Frame low, whoever drove that low. Period k is the clock after the k-th following edge. Local line i (bit i of `irq_in`) owns data frame f = i+1.
- R6: In period 3f-1 (Sample) the agent drives low if `irq_in[i]` was low at that edge. Otherwise it leaves the bus released.
- R7: In period 3f (Recovery) the agent drives high (`drv_en`=1, `drv_val`=1) only if it drove low in the Sample period just before. In period 3f+1 (Turn-around) it releases the bus.
- R8: In every other period of the cycle, including frames past the last local line, the agent keeps the bus released.
- R9: The Stop Frame low width counted at the clock edges sets the mode of the next cycle. A width below 3 clocks selects quiet mode and a width of 3 or more selects continuous mode.
- R10: A line change that reaches the agent at or before its frame's Sample edge in a running cycle counts as delivered and causes no new Start Frame. A change that arrives after that edge stays pending, and in quiet mode it opens a cycle once the Stop Frame has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 1 | Level of the serial interrupt wire as seen at this clock |
| irq_in | input | N_IRQ | Local interrupt/data lines, synchronous to `clk`; bit i owns frame i+1 |
| drv_en | output | 1 | Drive enable for the bus pad (0 = released) |
| drv_val | output | 1 | Level driven when `drv_en` is 1 |

## Verification
The assertions assume that `bus_in` follows the agent's own drive whenever nobody else pulls the wire low, as an open-drain wire with a pull-up does. They also assume that the host never overlaps the agent's one-clock pulse with a high level, and that `irq_in` is already synchronous to `clk`. The bench models the wire as the host's low drive, else the agent's drive value, else high. The host takes over the low level in the cycle after the agent's pulse and changes local lines only on falling clock edges. Each Stop Frame ends with the wire high before any new activity.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOPW = 3'd3,
    ST_STOP  = 3'd4
  } sirq_st_e;

endpackage

// File: rtl/sirq_frame_timer.sv
module sirq_frame_timer
  import sirq_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int N_FRAMES = 6,
  parameter int CONT_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_in,
  output sirq_st_e         st_o,
  output logic             idle_o,
  output logic             in_data_o,
  output logic             mode_quiet_o,
  output logic [N_IRQ-1:0] samp_hit_o,
  output logic [N_IRQ-1:0] rec_hit_o
);

  localparam int LASTK = 3 * N_FRAMES + 1;
  localparam int CW    = $clog2(LASTK + 1);
  localparam int LW    = $clog2(CONT_MIN + 1);

  sirq_st_e       st;
  logic [CW-1:0]  cnt;
  logic [LW-1:0]  low_cnt;
  logic           mode_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      low_cnt    <= '0;
      mode_quiet <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:  if (!bus_in) st <= ST_START;
        ST_START: if (bus_in) begin
                    st  <= ST_DATA;
                    cnt <= CW'(1);
                  end
        ST_DATA:  begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(LASTK)) st <= ST_STOPW;
                  end
        ST_STOPW: if (!bus_in) begin
                    st      <= ST_STOP;
                    low_cnt <= LW'(1);
                  end
        ST_STOP:  begin
                    if (!bus_in) begin
                      if (low_cnt != LW'(CONT_MIN)) low_cnt <= low_cnt + LW'(1);
                    end else begin
                      mode_quiet <= (low_cnt < LW'(CONT_MIN));
                      st         <= ST_IDLE;
                    end
                  end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_slot
    assign samp_hit_o[i] = (st == ST_DATA) && (cnt == CW'(3 * i + 2));
    assign rec_hit_o[i]  = (st == ST_DATA) && (cnt == CW'(3 * i + 3));
  end

  assign st_o         = st;
  assign idle_o       = (st == ST_IDLE);
  assign in_data_o    = (st == ST_DATA);
  assign mode_quiet_o = mode_quiet;

  // R5
  data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (cnt >= CW'(1) && cnt <= CW'(LASTK)));

  // R9
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && bus_in) |=> (st == ST_IDLE));

endmodule

// File: rtl/sirq_irq_tracker.sv
module sirq_irq_tracker #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] samp_hit,
  input  logic             idle,
  input  logic             mode_quiet,
  input  logic             bus_in,
  output logic             start_fire
);

  logic [N_IRQ-1:0] irq_q;
  logic [N_IRQ-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= '1;
      pending <= '0;
    end else begin
      irq_q   <= irq_in;
      pending <= (pending | (irq_in ^ irq_q)) & ~samp_hit;
    end
  end

  assign start_fire = idle && mode_quiet && bus_in && (|pending);

  // R10
  delivered_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|samp_hit) |=> ((pending & $past(samp_hit)) == '0));

endmodule

// File: rtl/sirq_drive.sv
module sirq_drive #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fire,
  input  logic             in_data,
  input  logic [N_IRQ-1:0] samp_hit,
  input  logic [N_IRQ-1:0] rec_hit,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             drv_en,
  output logic             drv_val
);

  logic drove;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_en  <= 1'b0;
      drv_val <= 1'b1;
      drove   <= 1'b0;
    end else begin
      drv_en  <= 1'b0;
      drv_val <= 1'b1;
      drove   <= 1'b0;
      if (start_fire) begin
        drv_en  <= 1'b1;
        drv_val <= 1'b0;
      end else if (in_data) begin
        if (|(samp_hit & ~irq_in)) begin
          drv_en  <= 1'b1;
          drv_val <= 1'b0;
          drove   <= 1'b1;
        end else if ((|rec_hit) && drove) begin
          drv_en  <= 1'b1;
          drv_val <= 1'b1;
        end
      end
    end
  end

  // R3
  start_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (drv_en && !drv_val) ##1 !drv_en);

  // R7
  turnaround_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |=> !drv_en);

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int N_FRAMES = 6,
  parameter int CONT_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_in,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             drv_en,
  output logic             drv_val
);

  sirq_st_e         st;
  logic             idle;
  logic             in_data;
  logic             mode_quiet;
  logic [N_IRQ-1:0] samp_hit;
  logic [N_IRQ-1:0] rec_hit;
  logic             start_fire;

  sirq_frame_timer #(
    .N_IRQ(N_IRQ), .N_FRAMES(N_FRAMES), .CONT_MIN(CONT_MIN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .st_o(st), .idle_o(idle), .in_data_o(in_data),
    .mode_quiet_o(mode_quiet), .samp_hit_o(samp_hit), .rec_hit_o(rec_hit)
  );

  sirq_irq_tracker #(.N_IRQ(N_IRQ)) u_track (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .samp_hit(samp_hit),
    .idle(idle), .mode_quiet(mode_quiet), .bus_in(bus_in),
    .start_fire(start_fire)
  );

  sirq_drive #(.N_IRQ(N_IRQ)) u_drive (
    .clk(clk), .rst_n(rst_n), .start_fire(start_fire), .in_data(in_data),
    .samp_hit(samp_hit), .rec_hit(rec_hit), .irq_in(irq_in),
    .drv_en(drv_en), .drv_val(drv_val)
  );

  // R2
  cont_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && drv_en) |-> mode_quiet);

  // R4
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && drv_en && !drv_val) |-> ($past(bus_in) && $past(st) == ST_IDLE));

  // R7
  recover_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !drv_val && st == ST_DATA) |=> (drv_en && drv_val));

endmodule

// File: tb/tb_sirq_agent.sv
module tb_sirq_agent;

  localparam int N_IRQ    = 4;
  localparam int N_FRAMES = 6;
  localparam int LASTK    = 3 * N_FRAMES + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_low = 1'b0;
  logic [N_IRQ-1:0] irq = '1;
  logic             drv_en;
  logic             drv_val;
  wire              bus_in = host_low ? 1'b0 : (drv_en ? drv_val : 1'b1);

  int checks = 0;
  int errors = 0;
  logic en_log  [0:LASTK];
  logic val_log [0:LASTK];

  always #5 clk = ~clk;

  sirq_agent #(.N_IRQ(N_IRQ), .N_FRAMES(N_FRAMES), .CONT_MIN(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .irq_in(irq),
    .drv_en(drv_en), .drv_val(drv_val)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Watch for an agent Start Frame; when one is seen the host takes over the low.
  task automatic wait_start(input bit exp, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (drv_en) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen == exp, tag, int'(seen), int'(exp));
    if (seen) begin
      chk(drv_val == 1'b0, "R3 start pulse level", int'(drv_val), 0);
      host_low = 1'b1;
      @(negedge clk);
      chk(drv_en == 1'b0, "R3 release after one clock", int'(drv_en), 0);
    end
  endtask

  // One bus cycle run by the host; checks the agent's drive in every period.
  task automatic host_cycle(input bit agent_started, input int start_lo, input int stop_lo,
                            input int chg_k, input logic [N_IRQ-1:0] chg_val,
                            input logic [N_IRQ-1:0] exp_irq);
    if (!agent_started) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    repeat (start_lo - 1) @(negedge clk);
    host_low = 1'b0;
    @(posedge clk);
    for (int k = 1; k <= LASTK; k++) begin
      @(posedge clk);
      @(negedge clk);
      en_log[k]  = drv_en;
      val_log[k] = drv_val;
      if (k == chg_k) irq = chg_val;
    end
    for (int k = 1; k <= LASTK; k++) begin
      bit ee = 1'b0;
      bit ev = 1'b1;
      string tag = "R8 idle period (also R4)";
      for (int f = 1; f <= N_FRAMES; f++) begin
        if (k == 3 * f - 1) tag = "R6 sample period";
        if (k == 3 * f)     tag = "R7 recovery period";
        if (k == 3 * f + 1) tag = "R7 turn-around period";
        if (f <= N_IRQ && exp_irq[f-1] == 1'b0) begin
          if (k == 3 * f - 1) begin ee = 1'b1; ev = 1'b0; end
          if (k == 3 * f)     begin ee = 1'b1; ev = 1'b1; end
        end
      end
      if (k == 1) tag = "R5 first period";
      chk(en_log[k] == ee, tag, int'(en_log[k]), int'(ee));
      if (ee) chk(val_log[k] == ev, tag, int'(val_log[k]), int'(ev));
    end
    @(negedge clk);
    host_low = 1'b1;
    repeat (stop_lo) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b0, "R1 released after reset", int'(drv_en), 0);
    irq = 4'b1110;
    wait_start(1'b0, "R1 no start in reset mode");
  endtask

  task automatic t_cont_cycle();
    host_cycle(1'b0, 5, 3, -1, '0, 4'b1110);
    irq = 4'b1010;
    wait_start(1'b0, "R2 continuous stays passive");
  endtask

  task automatic t_to_quiet();
    host_cycle(1'b0, 4, 2, -1, '0, 4'b1010);
    wait_start(1'b0, "R10 nothing pending after delivery");
  endtask

  task automatic t_quiet_start();
    irq = 4'b0010;
    wait_start(1'b1, "R9 quiet mode start on change");
    host_cycle(1'b1, 3, 2, -1, '0, 4'b0010);
  endtask

  task automatic t_inflight();
    host_cycle(1'b0, 4, 2, 1, 4'b0011, 4'b0011);
    wait_start(1'b0, "R10 in-flight change delivered");
  endtask

  task automatic t_late();
    host_cycle(1'b0, 6, 2, 5, 4'b0010, 4'b0011);
    wait_start(1'b1, "R10 late change starts after stop");
    host_cycle(1'b1, 4, 3, -1, '0, 4'b0010);
  endtask

  task automatic t_back_cont();
    irq = 4'b0110;
    wait_start(1'b0, "R9 wide stop selects continuous");
  endtask

  initial begin
    t_reset();
    t_cont_cycle();
    t_to_quiet();
    t_quiet_start();
    t_inflight();
    t_late();
    t_back_cont();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule